// File: doc/BRIEF.md
# Transmit Broadcast Frame Counter

This block keeps a statistics count of broadcast frames that leave an Ethernet transmit path. Each finished transmission arrives as one completion event carrying three descriptor flags. The first flag says whether the host queued the frame or whether it was made inside the controller, as a flow-control or manageability frame. The second says whether the destination was broadcast. The third marks a secure frame. Counting only happens while the global transmit-enable input is high. The running total is exposed as a read-only value, `CNT_W` bits wide with a default of 32. It stops at all ones instead of wrapping.

Internally made frames have no destination class of their own for this count. A one-bit sticky flag records whether the last host frame was broadcast. An internal frame counts as broadcast whenever that flag is set. The flag changes only when a host frame completes, and it clears when the host sends a non-broadcast frame.

The event input uses a valid/ready handshake. The block accepts one event on every clock, so `ev_ready` stays high and the source never sees back-pressure. An event is taken in any cycle where both `ev_valid` and `ev_ready` are high. Reset is synchronous and active high.

Top module: `txbc_counter`

## Requirements
- R1: A clock edge with `rst` high sets `count` to zero and clears the sticky flag to non-broadcast.
- R2: An accepted host event (`ev_host`=1) with `ev_bcast`=1 while `tx_en`=1 raises `count` by exactly one, visible after that same clock edge.
- R3: An accepted host event with `ev_bcast`=0 leaves `count` unchanged.
- R4: The `ev_secure` flag has no effect on whether an event is counted.
- R5: An accepted internal event (`ev_host`=0) while `tx_en`=1 raises `count` by one if the last host event was broadcast, and leaves it unchanged otherwise. The internal event's own `ev_bcast` flag is ignored.
- R6: The sticky flag takes the value of `ev_bcast` on every accepted host event, including when `tx_en`=0. Internal events and idle cycles leave it unchanged.
- R7: While `tx_en`=0, `count` does not change.
- R8: When `count` is all ones it stays all ones. It does not wrap to zero.
- R9: `ev_ready` is always 1. A cycle with `ev_valid`=0 changes neither `count` nor the sticky flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Global transmit enable; gates counting |
| ev_valid | input | 1 | A completion event is present |
| ev_ready | output | 1 | Event accepted; always 1 |
| ev_host | input | 1 | 1: frame came from the host; 0: internal flow-control or manageability frame |
| ev_bcast | input | 1 | Destination is broadcast (used only for host frames) |
| ev_secure | input | 1 | Secure frame marker; does not affect the count |
| count | output | CNT_W | Saturating broadcast frame count, read-only |

## Verification
The sticky flag is internal, so a wrong value in it shows up only on the next accepted internal event while transmit is enabled. In that cycle `count` either fails to advance or advances when it should not, and the bench places internal events straight after host events of each class so the error appears one edge later. An error in the counter path, such as a missing gate, a wrap at the top or a double step, shows at `count` one edge after the faulty event. The bench sweeps every flag combination from both sticky states and then drives the narrow counter into saturation.

// File: rtl/txbc_pkg.sv
package txbc_pkg;

  typedef struct packed {
    logic host;
    logic bcast;
    logic secure;
  } txbc_evt_t;

  function automatic logic txbc_is_bcast(input txbc_evt_t e, input logic last_host_bcast);
    return e.host ? e.bcast : last_host_bcast;
  endfunction

endpackage

// File: rtl/txbc_classify.sv
module txbc_classify
  import txbc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tx_en,
  input  logic      fire,
  input  txbc_evt_t evt,
  output logic      bump,
  output logic      sticky
);

  logic sticky_q;

  always_ff @(posedge clk) begin
    if (rst)
      sticky_q <= 1'b0;
    else if (fire && evt.host)
      sticky_q <= evt.bcast;
  end

  assign sticky = sticky_q;
  assign bump   = fire && tx_en && txbc_is_bcast(evt, sticky_q);

  // R6: the flag follows a host event's class, whether or not transmit is enabled
  a_r6_sticky_follows_host: assert property (@(posedge clk) disable iff (rst)
    (fire && evt.host) |=> (sticky_q == $past(evt.bcast)));

  // R6: internal events and idle cycles leave the flag alone
  a_r6_sticky_holds: assert property (@(posedge clk) disable iff (rst)
    !(fire && evt.host) |=> $stable(sticky_q));

endmodule

// File: rtl/txbc_satcnt.sv
module txbc_satcnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] value
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (inc && (cnt_q != TOP))
      cnt_q <= cnt_q + 1'b1;
  end

  assign value = cnt_q;

  // R8: once at all ones, the count stays there
  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == TOP) |=> (cnt_q == TOP));

  // R2: an accepted step below the top advances by exactly one
  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    (inc && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/txbc_counter.sv
module txbc_counter
  import txbc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic             ev_host,
  input  logic             ev_bcast,
  input  logic             ev_secure,
  output logic [CNT_W-1:0] count
);

  txbc_evt_t evt;
  logic      fire;
  logic      bump;
  logic      sticky;

  assign ev_ready = 1'b1;
  assign fire     = ev_valid && ev_ready;
  assign evt      = '{host: ev_host, bcast: ev_bcast, secure: ev_secure};

  txbc_classify u_classify (
    .clk    (clk),
    .rst    (rst),
    .tx_en  (tx_en),
    .fire   (fire),
    .evt    (evt),
    .bump   (bump),
    .sticky (sticky)
  );

  txbc_satcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (bump),
    .value (count)
  );

  // R7: disabled transmit never moves the count
  a_r7_hold_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> $stable(count));

  // R9: an idle input never moves the count
  a_r9_idle_no_change: assert property (@(posedge clk) disable iff (rst)
    !ev_valid |=> $stable(count));

  // R3: a host non-broadcast frame is never counted
  a_r3_host_nonbcast: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_host && !ev_bcast) |=> $stable(count));

  // R5: an internal frame after a host non-broadcast frame is not counted
  a_r5_internal_clear: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !ev_host && !sticky) |=> $stable(count));

  // R1: reset leaves the count at zero
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (count == '0));

endmodule

// File: tb/txbc_counter_bench.sv
module txbc_counter_bench;

  localparam int W = 4;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tx_en = 1'b0;
  logic         ev_valid = 1'b0;
  logic         ev_host = 1'b0;
  logic         ev_bcast = 1'b0;
  logic         ev_secure = 1'b0;
  logic         ev_ready;
  logic [W-1:0] count;

  int checks = 0;
  int fails = 0;
  int exp_cnt = 0;
  bit exp_sticky = 1'b0;

  always #10 clk = ~clk;

  txbc_counter #(.CNT_W(W)) u_txbc_counter (
    .clk(clk), .rst(rst), .tx_en(tx_en), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_host(ev_host), .ev_bcast(ev_bcast), .ev_secure(ev_secure), .count(count)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock with the given inputs; the bench model is updated alongside
  task automatic step(input bit en, input bit v, input bit h, input bit b, input bit s, input string req);
    bit bcast_cls;
    @(negedge clk);
    tx_en = en; ev_valid = v; ev_host = h; ev_bcast = b; ev_secure = s;
    check("R9", int'(ev_ready), 1);
    bcast_cls = h ? b : exp_sticky;
    if (v && en && bcast_cls && exp_cnt < MAXV) exp_cnt++;
    if (v && h) exp_sticky = b;
    @(posedge clk);
    #1;
    check(req, int'(count), exp_cnt);
    ev_valid = 1'b0;
  endtask

  initial begin : watchdog
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R1", int'(count), 0);
    @(negedge clk);
    rst = 1'b0;

    // R5: from reset the flag is clear, so an internal frame does not count
    step(1, 1, 0, 1, 0, "R5");

    // sweep every flag combination from each sticky state
    for (int pr = 0; pr < 2; pr++) begin
      for (int c = 0; c < 16; c++) begin
        // prime the flag with transmit disabled (R6, R7)
        step(0, 1, 1, pr[0], 0, "R7");
        // a disabled internal frame must not disturb the flag (R6)
        step(0, 1, 0, ~pr[0], 1, "R6");
        step(c[3], 1, c[2], c[1], c[0],
             c[2] ? (c[1] ? "R2" : "R3") : (c[3] ? "R5" : "R7"));
        // R4: secure flips nothing; R6: probe the flag with an enabled internal frame
        step(1, 1, 0, 0, ~c[0], "R6");
        // R9: an idle cycle with flags set changes nothing
        step(1, 0, 1, 1, 1, "R9");
        if (exp_cnt >= MAXV - 4) begin
          @(negedge clk);
          rst = 1'b1;
          @(posedge clk);
          #1;
          exp_cnt = 0;
          exp_sticky = 1'b0;
          check("R1", int'(count), 0);
          @(negedge clk);
          rst = 1'b0;
          step(1, 1, 0, 1, 1, "R1");
        end
      end
    end

    // R4: a secure host broadcast counts like a standard one
    step(1, 1, 1, 1, 1, "R4");
    step(1, 1, 1, 1, 0, "R4");

    // R8: drive past the top with host and inherited broadcasts
    for (int k = 0; k < MAXV + 4; k++)
      step(1, 1, k[0], 1, 0, "R8");
    check("R8", int'(count), MAXV);
    step(1, 1, 0, 0, 0, "R8");

    // R6: a host non-broadcast clears inheritance, then internal frames stop counting
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    exp_cnt = 0;
    exp_sticky = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    step(1, 1, 1, 1, 0, "R2");
    step(1, 1, 0, 0, 0, "R5");
    step(1, 1, 1, 0, 0, "R3");
    step(1, 1, 0, 1, 0, "R6");
    check("R6", int'(count), 2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule